// File: doc/BRIEF.md
# Fractional Sample Block Cadence Generator

This block paces one audio stream onto a link whose frames arrive at a fixed 48 kHz. On every frame tick it decides how many sample blocks the stream carries in that frame, so that the average delivered rate equals the programmed sample rate. The rate is programmed as a base family (48 kHz or 44.1 kHz), an integer multiplier and an integer divisor. Each stream instance runs on its own, so several instances with different rates can share the same frame tick.

Internally the rate becomes a numerator and a denominator per frame. For the 48 kHz family these are the multiplier and the divisor. For the 44.1 kHz family they are 147 times the multiplier and 160 times the divisor. An accumulator adds the numerator on every frame. Each whole denominator that it passes turns into one block, and the remainder carries into the next frame. This spreads blocks as evenly as the frame grid allows, and over a long run it delivers exactly 147 blocks per 160 frames for the plain 44.1 kHz rate. A check counter totals the blocks over each window of 160 frames.

Top module: `cadence_gen`

## Requirements
- R1: After reset, `blocks_o`, `win_count_o` and `win_done_o` are all zero.
- R2: With `base_sel_i` = 0 (48 kHz family) and divisor 1, every frame tick sets `blocks_o` to the multiplier.
- R3: With `base_sel_i` = 0, multiplier 1 and divisor n, `blocks_o` is 1 on the n-th, 2n-th, ... frame after the configuration took effect, and 0 on the n-1 frames between.
- R4: With `base_sel_i` = 1 (44.1 kHz family), each frame adds 147×multiplier to an accumulator. `blocks_o` is floor((acc + 147×mult) / (160×div)), and the remainder is kept for the next frame. The 48 kHz family follows the same rule with numerator mult and denominator div.
- R5: At 44.1 kHz with multiplier 1 and divisor 1, every completed 160-frame window reports `win_count_o` = 147.
- R6: `blocks_o` never exceeds the active multiplier.
- R7: A change on any rate input takes effect at the next frame tick. That tick starts from a cleared accumulator and a cleared window, and it counts as the first frame of the new setting.
- R8: `blocks_o` changes only in the cycle after a frame tick. Rate-input changes between ticks do not alter it.
- R9: `win_done_o` pulses for one cycle after every 160th frame since reset or since the last rate change. `win_count_o` then holds the sum of `blocks_o` over those 160 frames.
- R10: The rate inputs must stay in the supported range: multiplier 1..MAX_MULT and divisor 1..MAX_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | One-cycle pulse per 48 kHz link frame |
| base_sel_i | input | 1 | Rate family: 0 = 48 kHz, 1 = 44.1 kHz |
| mult_i | input | $clog2(MAX_MULT+1) | Rate multiplier |
| div_i | input | $clog2(MAX_DIV+1) | Rate divisor |
| blocks_o | output | $clog2(MAX_MULT+1) | Sample blocks carried in the current frame |
| win_count_o | output | $clog2(160*MAX_MULT+1) | Block total of the last completed 160-frame window |
| win_done_o | output | 1 | One-cycle pulse when a window completes |

## Verification
The assertions assume that the multiplier and divisor never leave their supported range and that frame ticks are single-cycle pulses. Under those conditions the accumulator remainder stays below the denominator and the window logic never sees two completions in a row. The stimulus sweeps every base, multiplier and divisor inside the range. It changes the setting only between ticks and inserts idle cycles after each tick, so the held output and the one-cycle window pulse can both be observed. Each setting runs for 200 frames. That is not a multiple of the window length, so every change also lands in the middle of a window.

// File: rtl/cadence_pkg.sv
package cadence_pkg;
  typedef enum logic {
    BASE_48K = 1'b0,
    BASE_44K = 1'b1
  } base_e;

  // 44.1 kHz family: 147 blocks per 160 frames
  localparam int FAM_NUM       = 147;
  localparam int FAM_DEN       = 160;
  localparam int WINDOW_FRAMES = 160;
endpackage

// File: rtl/cadence_rate.sv
module cadence_rate
  import cadence_pkg::*;
#(
  parameter int MULT_W = 3,
  parameter int DIV_W  = 4,
  parameter int ACC_W  = 12
) (
  input  logic              base_sel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [ACC_W-1:0]  num_o,
  output logic [ACC_W-1:0]  den_o
);
  localparam logic [ACC_W-1:0] NUM_K = ACC_W'(FAM_NUM);
  localparam logic [ACC_W-1:0] DEN_K = ACC_W'(FAM_DEN);

  always_comb begin
    if (base_e'(base_sel_i) == BASE_44K) begin
      num_o = NUM_K * ACC_W'(mult_i);
      den_o = DEN_K * ACC_W'(div_i);
    end else begin
      num_o = ACC_W'(mult_i);
      den_o = ACC_W'(div_i);
    end
  end
endmodule

// File: rtl/cadence_divider.sv
module cadence_divider #(
  parameter int ACC_W = 12,
  parameter int Q_W   = 3,
  parameter int MAX_Q = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ACC_W-1:0] den_i,
  output logic [Q_W-1:0]   quot_o,
  output logic [ACC_W-1:0] rem_o
);
  localparam int PROD_W = ACC_W + Q_W + 1;

  logic [MAX_Q-1:0] ge;

  // thermometer of quotient candidates
  for (genvar k = 1; k <= MAX_Q; k++) begin : g_cmp
    assign ge[k-1] = PROD_W'(sum_i) >= PROD_W'(k) * PROD_W'(den_i);
  end

  always_comb begin
    quot_o = '0;
    for (int k = 0; k < MAX_Q; k++) quot_o = quot_o + Q_W'(ge[k]);
  end

  assign rem_o = ACC_W'(PROD_W'(sum_i) - PROD_W'(quot_o) * PROD_W'(den_i));

  // R4
  rem_below_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_i != '0) |-> (rem_o < den_i));
endmodule

// File: rtl/cadence_window.sv
module cadence_window #(
  parameter int WIN    = 160,
  parameter int Q_W    = 3,
  parameter int WCNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic [Q_W-1:0]    blocks_i,
  output logic [WCNT_W-1:0] count_o,
  output logic              done_o
);
  localparam int FC_W = $clog2(WIN);

  logic [FC_W-1:0]   frame_q, frame_eff;
  logic [WCNT_W-1:0] sum_q, sum_eff;

  assign frame_eff = clear_i ? '0 : frame_q;
  assign sum_eff   = clear_i ? '0 : sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      sum_q   <= '0;
      count_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (frame_eff == FC_W'(WIN - 1)) begin
          count_o <= sum_eff + WCNT_W'(blocks_i);
          done_o  <= 1'b1;
          frame_q <= '0;
          sum_q   <= '0;
        end else begin
          frame_q <= frame_eff + 1'b1;
          sum_q   <= sum_eff + WCNT_W'(blocks_i);
        end
      end
    end
  end

  // R9
  done_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tick_i));
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/cadence_gen.sv
module cadence_gen
  import cadence_pkg::*;
#(
  parameter int MAX_MULT = 4,
  parameter int MAX_DIV  = 8,
  localparam int MULT_W  = $clog2(MAX_MULT + 1),
  localparam int DIV_W   = $clog2(MAX_DIV + 1),
  localparam int WCNT_W  = $clog2(WINDOW_FRAMES * MAX_MULT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic              base_sel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [MULT_W-1:0] blocks_o,
  output logic [WCNT_W-1:0] win_count_o,
  output logic              win_done_o
);
  localparam int ACC_W = $clog2(FAM_DEN * MAX_DIV + FAM_NUM * MAX_MULT) + 1;

  logic              base_q;
  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;
  logic [ACC_W-1:0]  acc_q, acc_eff, num, den, sum, rem;
  logic [MULT_W-1:0] quot;
  logic              changed;

  assign changed = (base_sel_i != base_q) || (mult_i != mult_q) || (div_i != div_q);
  assign acc_eff = changed ? '0 : acc_q;
  assign sum     = acc_eff + num;

  cadence_rate #(
    .MULT_W(MULT_W), .DIV_W(DIV_W), .ACC_W(ACC_W)
  ) u_rate (
    .base_sel_i(base_sel_i), .mult_i(mult_i), .div_i(div_i),
    .num_o(num), .den_o(den)
  );

  cadence_divider #(
    .ACC_W(ACC_W), .Q_W(MULT_W), .MAX_Q(MAX_MULT)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sum_i(sum), .den_i(den), .quot_o(quot), .rem_o(rem)
  );

  cadence_window #(
    .WIN(WINDOW_FRAMES), .Q_W(MULT_W), .WCNT_W(WCNT_W)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(frame_tick_i), .clear_i(changed), .blocks_i(quot),
    .count_o(win_count_o), .done_o(win_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= BASE_48K;
      mult_q   <= MULT_W'(1);
      div_q    <= DIV_W'(1);
      acc_q    <= '0;
      blocks_o <= '0;
    end else if (frame_tick_i) begin
      base_q   <= base_sel_i;
      mult_q   <= mult_i;
      div_q    <= div_i;
      acc_q    <= rem;
      blocks_o <= quot;
    end
  end

  // R10
  cfg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_i |-> (mult_i >= 1 && 32'(mult_i) <= MAX_MULT &&
                      div_i >= 1 && 32'(div_i) <= MAX_DIV));
  // R6
  blocks_le_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocks_o <= mult_q);
  // R8
  blocks_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_tick_i) |-> $stable(blocks_o));
  // R2
  full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_tick_i) && base_q == BASE_48K && div_q == DIV_W'(1))
      |-> blocks_o == mult_q);
  // R5
  window_147_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_o && base_q == BASE_44K && mult_q == MULT_W'(1) && div_q == DIV_W'(1))
      |-> win_count_o == WCNT_W'(147));
endmodule

// File: tb/sim_cadence_gen.sv
module sim_cadence_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_MULT   = 4;
  localparam int MAX_DIV    = 8;
  localparam int MULT_W     = $clog2(MAX_MULT + 1);
  localparam int DIV_W      = $clog2(MAX_DIV + 1);
  localparam int WCNT_W     = $clog2(160 * MAX_MULT + 1);
  localparam int FRAMES     = 200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              base = 1'b0;
  logic [MULT_W-1:0] mult = MULT_W'(1);
  logic [DIV_W-1:0]  div = DIV_W'(1);
  logic [MULT_W-1:0] blocks;
  logic [WCNT_W-1:0] wcount;
  logic              wdone;

  int checks = 0, fails = 0;
  int acc = 0, fcnt = 0, wsum = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cadence_gen #(.MAX_MULT(MAX_MULT), .MAX_DIV(MAX_DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick),
    .base_sel_i(base), .mult_i(mult), .div_i(div),
    .blocks_o(blocks), .win_count_o(wcount), .win_done_o(wdone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R7: new setting applied between ticks; model clears its state
  task automatic set_cfg(input bit b, input int m, input int d);
    @(negedge clk);
    if (b != base || m != int'(mult) || d != int'(div)) begin
      acc = 0; fcnt = 0; wsum = 0;
    end
    base = b; mult = MULT_W'(m); div = DIV_W'(d);
  endtask

  task automatic frame(input string req);
    int num, den, q;
    num = base ? 147 * int'(mult) : int'(mult);
    den = base ? 160 * int'(div) : int'(div);
    q   = (acc + num) / den;
    acc = (acc + num) % den;
    fcnt++; wsum += q;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(req, int'(blocks), q);
    check("R6", int'(blocks <= mult), 1);
    if (fcnt == 160) begin
      check("R9", int'(wdone), 1);
      check("R9", int'(wcount), wsum);
      if (base && mult == 1 && div == 1) check("R5", int'(wcount), 147);
      fcnt = 0; wsum = 0;
    end else begin
      check("R9", int'(wdone), 0);
    end
    @(negedge clk);
    check("R8", int'(blocks), q);
    check("R9", int'(wdone), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", int'(blocks), 0);
    check("R1", int'(wcount), 0);
    check("R1", int'(wdone), 0);
    rst_n = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int m = 1; m <= MAX_MULT; m++)
        for (int d = 1; d <= MAX_DIV; d++) begin
          set_cfg(b[0], m, d);
          for (int f = 0; f < FRAMES; f++) begin
            if (b == 1) frame("R4");
            else if (d == 1) frame("R2");
            else if (m == 1) frame("R3");
            else frame("R4");
          end
        end
    // R8: rate change between ticks leaves the held count untouched
    set_cfg(1'b0, 3, 1);
    frame("R2");
    @(negedge clk); mult = MULT_W'(1); div = DIV_W'(2);
    @(negedge clk);
    check("R8", int'(blocks), 3);
    acc = 0; fcnt = 0; wsum = 0;
    frame("R3");
    frame("R3");
    // R7: mid-window change back to 44.1 kHz, then a full clean window
    set_cfg(1'b1, 1, 1);
    for (int f = 0; f < 320; f++) frame("R5");
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule